// File: doc/BRIEF.md
# Probabilistic Bit-Flipping Variable Node

This block is one variable-node processing element for a hard-decision LDPC decoder that runs probabilistic gradient-descent bit flipping. It keeps the current hard decision for a single code position. At the start of a frame it loads the received channel bit. On each iteration it scores its own unreliability as an integer energy. That energy is the disagreement between the current bit and the channel bit, plus the number of neighbouring parity checks that are currently unsatisfied.

The node inverts its bit only when all of the following hold:
- its energy equals the decoder-wide maximum energy;
- the iteration strobe is present;
- a per-node random enable bit is 1.

The parity-check network, the maximum finder, the random source and the syndrome stop logic all sit outside the block. Their results arrive on input ports. The node exports its energy, for the maximum finder, and its current bit, for the check nodes. A parameter selects whether the energy output is combinational (the default) or registered.

Top module: `pbf_vnode`

## Requirements
- R1: `energy` equals (`bit_out` XOR `ch_bit`) plus the number of 1s on `chk_unsat`, as an unsigned value of ENERGY_W = clog2(DEG+2) bits that never exceeds DEG+1. With the default DEG=3 the width is 3 bits and the range is 0 to 4.
- R2: With `init`=0, `stop`=0, `iter_en`=1, `rnd`=1 and the node's energy equal to `e_max` at a rising edge, `bit_out` is inverted after that edge.
- R3: With `rnd`=0, `bit_out` keeps its value even when the energy equals `e_max`.
- R4: When the energy differs from `e_max`, `bit_out` keeps its value whatever `rnd` is.
- R5: With `iter_en`=0, `bit_out` keeps its value, so the bit changes at most once per strobed iteration.
- R6: With `stop`=1 (zero syndrome reached), `bit_out` is frozen.
- R7: With `init`=1, `bit_out` takes `ch_bit` at the next edge. This overrides any flip condition and also applies while `stop`=1.
- R8: A synchronous active-high `rst` clears `bit_out` to 0 and takes priority over `init`.
- R9: With REG_ENERGY=1, `energy` shows, one cycle later, the value defined in R1 from the inputs and state before the edge, and reset clears it to 0. With REG_ENERGY=0 it follows the inputs without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Load the channel bit into the node |
| iter_en | input | 1 | Iteration strobe qualifying a flip |
| stop | input | 1 | Zero-syndrome freeze |
| ch_bit | input | 1 | Received hard channel bit |
| chk_unsat | input | DEG | Parity results of the neighbouring checks, 1 = unsatisfied |
| e_max | input | ENERGY_W | Decoder-wide maximum energy |
| rnd | input | 1 | Random flip enable for this node |
| energy | output | ENERGY_W | Node energy |
| bit_out | output | 1 | Current hard decision |

## Verification
The bench builds two copies with DEG=3: one with a combinational energy output and one with a registered energy output.

At this size the whole input space can be swept:
- both starting bits;
- both channel bits;
- all eight check patterns;
- all eight maximum-energy codes;
- every combination of the random, strobe and stop controls.

The sweep therefore covers every energy value from 0 to 4, every equal and unequal comparison against the maximum, and every gating combination. Further checks cover init overriding a flip condition, init loading while stopped, and reset overriding init.

// File: rtl/pbf_pkg.sv
package pbf_pkg;
  function automatic int unsigned energy_width(input int unsigned deg);
    return $clog2(deg + 2);
  endfunction
endpackage

// File: rtl/pbf_energy.sv
module pbf_energy #(
  parameter int unsigned DEG = 3,
  parameter int unsigned EW  = pbf_pkg::energy_width(DEG)
) (
  input  logic           cur_bit,
  input  logic           rx_bit,
  input  logic [DEG-1:0] unsat,
  output logic [EW-1:0]  energy_o
);
  logic [EW-1:0] acc;

  always_comb begin
    acc = {{(EW-1){1'b0}}, cur_bit ^ rx_bit};
    for (int i = 0; i < DEG; i++) begin
      acc = acc + {{(EW-1){1'b0}}, unsat[i]};
    end
  end

  assign energy_o = acc;
endmodule

// File: rtl/pbf_flip_ctl.sv
module pbf_flip_ctl #(
  parameter int unsigned EW = 3
) (
  input  logic          iter_en,
  input  logic          stop,
  input  logic          rnd,
  input  logic [EW-1:0] energy,
  input  logic [EW-1:0] e_max,
  output logic          flip
);
  logic at_max;

  assign at_max = (energy == e_max);
  assign flip   = iter_en & ~stop & rnd & at_max;
endmodule

// File: rtl/pbf_state.sv
module pbf_state (
  input  logic clk,
  input  logic rst,
  input  logic init,
  input  logic rx_bit,
  input  logic flip,
  output logic bit_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= 1'b0;
    end else if (init) begin
      bit_q <= rx_bit;
    end else if (flip) begin
      bit_q <= ~bit_q;
    end
  end

  // R8
  reset_clear_chk: assert property (@(posedge clk) rst |=> !bit_q);
  // R7
  init_load_chk: assert property (@(posedge clk) disable iff (rst)
    init |=> (bit_q == $past(rx_bit)));
endmodule

// File: rtl/pbf_vnode.sv
module pbf_vnode #(
  parameter int unsigned DEG        = 3,
  parameter bit          REG_ENERGY = 1'b0,
  localparam int unsigned ENERGY_W  = pbf_pkg::energy_width(DEG)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                init,
  input  logic                iter_en,
  input  logic                stop,
  input  logic                ch_bit,
  input  logic [DEG-1:0]      chk_unsat,
  input  logic [ENERGY_W-1:0] e_max,
  input  logic                rnd,
  output logic [ENERGY_W-1:0] energy,
  output logic                bit_out
);
  logic [ENERGY_W-1:0] energy_c;
  logic                flip;
  logic                bit_q;

  pbf_energy #(.DEG(DEG), .EW(ENERGY_W)) u_energy (
    .cur_bit (bit_q),
    .rx_bit  (ch_bit),
    .unsat   (chk_unsat),
    .energy_o(energy_c)
  );

  pbf_flip_ctl #(.EW(ENERGY_W)) u_flip (
    .iter_en(iter_en),
    .stop   (stop),
    .rnd    (rnd),
    .energy (energy_c),
    .e_max  (e_max),
    .flip   (flip)
  );

  pbf_state u_state (
    .clk   (clk),
    .rst   (rst),
    .init  (init),
    .rx_bit(ch_bit),
    .flip  (flip),
    .bit_q (bit_q)
  );

  generate
    if (REG_ENERGY) begin : g_energy_reg
      logic [ENERGY_W-1:0] energy_q;
      always_ff @(posedge clk) begin
        if (rst) energy_q <= '0;
        else     energy_q <= energy_c;
      end
      assign energy = energy_q;
    end else begin : g_energy_comb
      assign energy = energy_c;
    end
  endgenerate

  assign bit_out = bit_q;

  // R1
  energy_range_chk: assert property (@(posedge clk) disable iff (rst)
    energy_c <= ENERGY_W'(DEG + 1));
  // R2
  flip_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (!init && iter_en && !stop && rnd && (energy_c == e_max)) |=> (bit_out != $past(bit_out)));
  // R3
  rnd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!init && !rnd) |=> $stable(bit_out));
  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!init && stop) |=> $stable(bit_out));
  // R5
  strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!init && !iter_en) |=> $stable(bit_out));
endmodule

// File: tb/sim_pbf_vnode.sv
module sim_pbf_vnode;
  localparam int unsigned DEG = 3;
  localparam int unsigned EW  = 3;

  logic clk = 1'b0;
  logic rst, init, iter_en, stop, ch_bit, rnd;
  logic [DEG-1:0] chk_unsat;
  logic [EW-1:0]  e_max;
  logic [EW-1:0]  energy0, energy1;
  logic           bit0, bit1;
  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  pbf_vnode #(.DEG(DEG), .REG_ENERGY(1'b0)) u0 (
    .clk(clk), .rst(rst), .init(init), .iter_en(iter_en), .stop(stop),
    .ch_bit(ch_bit), .chk_unsat(chk_unsat), .e_max(e_max), .rnd(rnd),
    .energy(energy0), .bit_out(bit0)
  );

  pbf_vnode #(.DEG(DEG), .REG_ENERGY(1'b1)) u1 (
    .clk(clk), .rst(rst), .init(init), .iter_en(iter_en), .stop(stop),
    .ch_bit(ch_bit), .chk_unsat(chk_unsat), .e_max(e_max), .rnd(rnd),
    .energy(energy1), .bit_out(bit1)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    init = 0; iter_en = 0; stop = 0; rnd = 0; chk_unsat = '0; e_max = '0;
  endtask

  task automatic load(input logic b);
    @(negedge clk);
    idle();
    init = 1; ch_bit = b;
    @(negedge clk);
    init = 0;
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; ch_bit = 0; idle();
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 reset bit", int'(bit0), 0);
    check("R9 reset energy reg", int'(energy1), 0);
    rst = 0;

    // full sweep: R1 R2 R3 R4 R5 R6 R9
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 2; c++)
        for (int k = 0; k < 8; k++)
          for (int m = 0; m < 8; m++)
            for (int ctl = 0; ctl < 8; ctl++) begin
              int exp_e;
              int exp_b;
              load(logic'(b));
              ch_bit = logic'(c);
              chk_unsat = k[DEG-1:0];
              e_max = m[EW-1:0];
              rnd = ctl[0];
              iter_en = ctl[1];
              stop = ctl[2];
              exp_e = (b ^ c) + k[0] + k[1] + k[2];
              exp_b = (ctl[0] && ctl[1] && !ctl[2] && exp_e == m) ? 1 - b : b;
              #1;
              check("R1 energy", int'(energy0), exp_e);
              @(negedge clk);
              if (exp_b != b) check("R2 flip", int'(bit0), exp_b);
              else if (!ctl[0]) check("R3 rnd hold", int'(bit0), exp_b);
              else if (exp_e != m) check("R4 not max hold", int'(bit0), exp_b);
              else if (!ctl[1]) check("R5 strobe hold", int'(bit0), exp_b);
              else check("R6 stop hold", int'(bit0), exp_b);
              check("R9 registered energy", int'(energy1), exp_e);
            end

    // R7 init overrides flip condition
    load(1'b0);
    ch_bit = 1'b0; chk_unsat = 3'b111; e_max = 3'd3; rnd = 1; iter_en = 1;
    init = 1;
    @(negedge clk);
    check("R7 init over flip", int'(bit0), 0);
    // R7 init loads while stopped
    idle(); stop = 1; init = 1; ch_bit = 1;
    @(negedge clk);
    check("R7 init while stop", int'(bit0), 1);
    // R8 reset over init
    idle(); rst = 1; init = 1; ch_bit = 1;
    @(negedge clk);
    check("R8 reset over init", int'(bit0), 0);
    rst = 0; idle();
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule